// File: doc/BRIEF.md
# Four-Choice Programmable Logic Cell

This block is a k-input programmable logic cell. The top input bits (all but bit 0) form a row index into a configuration store of 2^(k-1) rows. Each row holds a 2-bit choice code that turns the row into one of four values: constant 0, constant 1, the pass-through input (bit 0 of `lut_in`), or the inverse of that input. A binary tree of two-input multiplexers then forwards the value of the addressed row to the output. Because the pass-through input enters the rows as data rather than as a select line, 2^(k-1) rows are enough to realize any k-input Boolean function.

The output is either taken straight from the tree (combinational mode) or from a D flip-flop that captures the tree value on every rising clock edge (registered mode). One configuration bit chooses between the two. Rows and the mode bit are written one at a time through a simple addressed write port. A synchronous active-high reset clears the flip-flop, every row and the mode bit. The parameter `K` may be 4, 5 or 6.

Top module: `lut4c_cell`

## Requirements
- R1: After a synchronous reset every row holds code 00 and the cell is in combinational mode, so `lut_out` is 0 for every value of `lut_in`.
- R2: Row codes mean: 00 gives 0, 01 gives 1, 10 gives `lut_in[0]`, 11 gives the inverse of `lut_in[0]`.
- R3: The row that drives the output is the one whose index equals `lut_in[K-1:1]`, with `lut_in[1]` as the least significant index bit.
- R4: In combinational mode `lut_out` follows a change of `lut_in` within the same clock cycle, without waiting for an edge.
- R5: In registered mode `lut_out` shows, after each rising edge, the function value of the `lut_in` and rows present just before that edge, and holds it while `lut_in` changes between edges.
- R6: A row write (`cfg_row_we` high at a rising edge) replaces only the row named by `cfg_row_idx` with `cfg_row_code`; all other rows keep their codes.
- R7: A mode write (`cfg_mode_we` high at a rising edge) sets registered mode when `cfg_mode_reg` is 1 and combinational mode when 0; the mode is unchanged otherwise.
- R8: When a row write and a flip-flop capture happen at the same edge, the flip-flop takes the value computed from the row before the write; the new code appears one edge later.
- R9: A reset applied in registered mode forces `lut_out` to 0 after the edge and also returns the cell to combinational mode with all rows cleared.
- R10: For any truth table of K inputs, programming each row with the code derived from its two table entries makes `lut_out` equal the table for all 2^K input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_row_we | input | 1 | Write strobe for one configuration row |
| cfg_row_idx | input | K-1 | Row number to write |
| cfg_row_code | input | 2 | Choice code written into the row |
| cfg_mode_we | input | 1 | Write strobe for the output mode bit |
| cfg_mode_reg | input | 1 | New mode: 1 registered, 0 combinational |
| lut_in | input | K | Logic inputs; bit 0 is the data input, the rest select the row |
| lut_out | output | 1 | Cell output |

## Verification
The two functions that can fall on one edge are a row rewrite and the flip-flop capture in registered mode. The bench provokes this by holding an input whose row it rewrites with the opposite constant at the very edge the flip-flop samples, then judges that the output first shows the old table value and only after the next edge the new one. Random truth tables, converted to row codes by a bench function, check the full input space in both modes around this directed case.

// File: rtl/lut4c_pkg.sv
package lut4c_pkg;
    typedef enum logic [1:0] {
        CH_ZERO = 2'b00,
        CH_ONE  = 2'b01,
        CH_PASS = 2'b10,
        CH_INV  = 2'b11
    } choice_e;
endpackage

// File: rtl/lut4c_cfg_store.sv
module lut4c_cfg_store #(
    parameter int K = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  row_we,
    input  logic [K-2:0]          row_idx,
    input  logic [1:0]            row_code,
    input  logic                  mode_we,
    input  logic                  mode_in,
    output logic [2*(2**(K-1))-1:0] row_codes,
    output logic                  mode_q
);
    localparam int ROWS = 2**(K-1);

    // one 2-bit register per row
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                row_codes[2*r +: 2] <= 2'b00;
            end else if (row_we && (row_idx == (K-1)'(r))) begin
                row_codes[2*r +: 2] <= row_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
        end else if (mode_we) begin
            mode_q <= mode_in;
        end
    end

    // R6: rows are untouched without a write strobe
    assert_rows_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !row_we |=> $stable(row_codes));

    // R6: a write alters at most the two bits of a single row
    assert_single_row_R6: assert property (@(posedge clk) disable iff (rst)
        row_we |=> ($countones(row_codes ^ $past(row_codes)) <= 2));

    // R7: mode bit only moves on a mode write
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !mode_we |=> $stable(mode_q));
endmodule

// File: rtl/lut4c_choice.sv
module lut4c_choice
    import lut4c_pkg::*;
#(
    parameter int K = 4
) (
    input  logic [2*(2**(K-1))-1:0] row_codes,
    input  logic                    data_in,
    output logic [2**(K-1)-1:0]     row_bits
);
    localparam int ROWS = 2**(K-1);

    for (genvar r = 0; r < ROWS; r++) begin : g_pick
        choice_e code;
        assign code = choice_e'(row_codes[2*r +: 2]);
        always_comb begin
            unique case (code)
                CH_ZERO: row_bits[r] = 1'b0;
                CH_ONE:  row_bits[r] = 1'b1;
                CH_PASS: row_bits[r] = data_in;
                CH_INV:  row_bits[r] = ~data_in;
                default: row_bits[r] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/lut4c_mux_tree.sv
module lut4c_mux_tree #(
    parameter int K = 4
) (
    input  logic [2**(K-1)-1:0] leaves,
    input  logic [K-2:0]        sel,
    output logic                root
);
    localparam int LEVELS = K - 1;
    localparam int ROWS   = 2**LEVELS;
    localparam int NODES  = 2*ROWS - 1;

    // heap layout: node i has children 2i+1 (sel bit 0) and 2i+2 (sel bit 1)
    logic [NODES-1:0] node;

    for (genvar r = 0; r < ROWS; r++) begin : g_leaf
        assign node[ROWS-1+r] = leaves[r];
    end

    for (genvar d = 0; d < LEVELS; d++) begin : g_level
        for (genvar j = 0; j < 2**d; j++) begin : g_mux
            localparam int I = (2**d) - 1 + j;
            assign node[I] = sel[LEVELS-1-d] ? node[2*I+2] : node[2*I+1];
        end
    end

    assign root = node[0];
endmodule

// File: rtl/lut4c_cell.sv
module lut4c_cell
    import lut4c_pkg::*;
#(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_row_we,
    input  logic [K-2:0] cfg_row_idx,
    input  logic [1:0]   cfg_row_code,
    input  logic         cfg_mode_we,
    input  logic         cfg_mode_reg,
    input  logic [K-1:0] lut_in,
    output logic         lut_out
);
    localparam int ROWS = 2**(K-1);

    logic [2*ROWS-1:0] row_codes;
    logic              mode_q;
    logic [ROWS-1:0]   row_bits;
    logic              tree_out;
    logic              ff_q;
    logic [K-2:0]      sel_idx;

    assign sel_idx = lut_in[K-1:1];

    lut4c_cfg_store #(.K(K)) u_store (
        .clk(clk), .rst(rst),
        .row_we(cfg_row_we), .row_idx(cfg_row_idx), .row_code(cfg_row_code),
        .mode_we(cfg_mode_we), .mode_in(cfg_mode_reg),
        .row_codes(row_codes), .mode_q(mode_q)
    );

    lut4c_choice #(.K(K)) u_choice (
        .row_codes(row_codes), .data_in(lut_in[0]), .row_bits(row_bits)
    );

    lut4c_mux_tree #(.K(K)) u_tree (
        .leaves(row_bits), .sel(sel_idx), .root(tree_out)
    );

    always_ff @(posedge clk) begin
        if (rst) ff_q <= 1'b0;
        else     ff_q <= tree_out;
    end

    assign lut_out = mode_q ? ff_q : tree_out;

    // code of the addressed row, read directly from the store for checking
    choice_e sel_code;
    assign sel_code = choice_e'(row_codes[{sel_idx, 1'b0} +: 2]);

    // R2/R3: constant codes reach the output in combinational mode
    assert_const_code_R2: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && (sel_code == CH_ZERO || sel_code == CH_ONE)) |->
        (lut_out == (sel_code == CH_ONE)));

    // R2/R3: data codes pass or invert the data input
    assert_data_code_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && (sel_code == CH_PASS || sel_code == CH_INV)) |->
        (lut_out == (lut_in[0] ^ (sel_code == CH_INV))));
endmodule

// File: tb/lut4c_cell_tb.sv
`timescale 1ns/1ps
module lut4c_cell_tb;
    localparam int K    = 4;
    localparam int ROWS = 2**(K-1);
    localparam int NIN  = 2**K;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_row_we = 1'b0;
    logic [K-2:0] cfg_row_idx = '0;
    logic [1:0]   cfg_row_code = 2'b00;
    logic         cfg_mode_we = 1'b0;
    logic         cfg_mode_reg = 1'b0;
    logic [K-1:0] lut_in = '0;
    logic         lut_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lut4c_cell #(.K(K)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_row_we(cfg_row_we), .cfg_row_idx(cfg_row_idx), .cfg_row_code(cfg_row_code),
        .cfg_mode_we(cfg_mode_we), .cfg_mode_reg(cfg_mode_reg),
        .lut_in(lut_in), .lut_out(lut_out)
    );

    function automatic logic [1:0] code_for(logic [NIN-1:0] tt, int row);
        logic f0, f1;
        f0 = tt[2*row];
        f1 = tt[2*row+1];
        if (!f0 && !f1) return 2'b00;
        if (f0 && f1)   return 2'b01;
        if (!f0 && f1)  return 2'b10;
        return 2'b11;
    endfunction

    task automatic check(logic act, logic exp, string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: lut_out=%b expected=%b lut_in=%0d t=%0t", req, act, exp, lut_in, $time);
        end
    endtask

    task automatic write_row(int idx, logic [1:0] code);
        @(negedge clk);
        cfg_row_we = 1'b1; cfg_row_idx = (K-1)'(idx); cfg_row_code = code;
        @(posedge clk); #1;
        cfg_row_we = 1'b0;
    endtask

    task automatic write_mode(logic m);
        @(negedge clk);
        cfg_mode_we = 1'b1; cfg_mode_reg = m;
        @(posedge clk); #1;
        cfg_mode_we = 1'b0;
    endtask

    task automatic load_table(logic [NIN-1:0] tt);
        for (int r = 0; r < ROWS; r++) write_row(r, code_for(tt, r));
    endtask

    task automatic check_comb(logic [NIN-1:0] tt, string req);
        for (int v = 0; v < NIN; v++) begin
            @(negedge clk);
            lut_in = K'(v);
            #1;
            check(lut_out, tt[v], req);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [NIN-1:0] tt;
        logic old_v;
        void'($urandom(32'h5eed_1234));

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: after reset every input gives 0
        check_comb('0, "R1");

        // R2/R3: each code in row 5, inputs 10 and 11
        for (int c = 0; c < 4; c++) begin
            write_row(5, 2'(c));
            @(negedge clk); lut_in = K'(10); #1;
            check(lut_out, (c == 1) || (c == 3), "R2 a=0");
            @(negedge clk); lut_in = K'(11); #1;
            check(lut_out, (c == 1) || (c == 2), "R2 a=1");
            // R6: neighbouring row 4 is untouched
            @(negedge clk); lut_in = K'(9); #1;
            check(lut_out, 1'b0, "R6 other row");
        end
        write_row(5, 2'b00);

        // R3: single-row one-hot patterns locate the index bits
        for (int r = 0; r < ROWS; r++) begin
            write_row(r, 2'b01);
            check_comb(NIN'(3) << (2*r), "R3");
            write_row(r, 2'b00);
        end

        // R10/R4: random truth tables, combinational mode
        for (int n = 0; n < 20; n++) begin
            tt = NIN'($urandom());
            load_table(tt);
            check_comb(tt, "R10 R4");
        end

        // R7/R5: registered mode
        tt = NIN'($urandom());
        load_table(tt);
        @(negedge clk); lut_in = '0;
        write_mode(1'b1);
        check(lut_out, tt[0], "R7 mode set");
        old_v = tt[0];
        for (int v = 0; v < NIN; v++) begin
            @(negedge clk); lut_in = K'(v); #1;
            check(lut_out, old_v, "R5 hold");
            @(posedge clk); #1;
            check(lut_out, tt[v], "R5 capture");
            old_v = tt[v];
        end

        // R8: row rewrite at the same edge as capture
        @(negedge clk);
        lut_in = K'(6);
        cfg_row_we = 1'b1; cfg_row_idx = (K-1)'(3);
        cfg_row_code = tt[6] ? 2'b00 : 2'b01;
        @(posedge clk); #1;
        cfg_row_we = 1'b0;
        check(lut_out, tt[6], "R8 old value");
        @(posedge clk); #1;
        check(lut_out, ~tt[6], "R8 new value");

        // R7: back to combinational
        write_mode(1'b0);
        @(negedge clk); lut_in = K'(7); #1;
        check(lut_out, ~tt[6], "R7 comb row3 const");

        // R9: reset in registered mode
        tt = NIN'($urandom()) | NIN'(1);
        load_table(tt);
        write_mode(1'b1);
        @(negedge clk); lut_in = '0; rst = 1'b1;
        @(posedge clk); #1;
        check(lut_out, 1'b0, "R9 ff cleared");
        @(negedge clk); rst = 1'b0;
        check_comb('0, "R9 rows and mode cleared");

        finish_run();
    end
endmodule